// File: doc/BRIEF.md
# Round-Trip Marker Delay Measurer

This block sits on the master end of a word-synchronous serial link whose far end echoes traffic back in lock with the master transmit clock. On request it places a reserved marker word into the outgoing word stream and starts counting transmit word clocks. It stops counting when the receive side presents the echoed marker. The echoed marker carries the far end's word-alignment shift count in its low byte. The block combines the word count with the local and far-end shift counts to give the loop delay in unit intervals (serial bit times).

A one-word start pulse marks the transmit word that holds the marker. A stop pulse marks the completion, so an instrument can time the same interval from outside. Half of the loop delay is also presented as a first estimate of the one-way offset. If no marker comes back before the word counter reaches its limit, the measurement is abandoned and a timeout flag is raised.

Top module: `rtmk_delay_meter`

## Requirements
- R1: After reset the block is idle. `start_pulse_o`, `stop_pulse_o`, `result_valid_o`, `busy_o` and `timeout_o` are low, and `tx_word_o`/`tx_ctrl_o` pass `tx_data_i`/`tx_ctrl_i` through unchanged.
- R2: A launch request is accepted at a clock edge where it is high while the block is idle and `link_aligned_i` is high. In the next cycle, and only that cycle:
  - `tx_ctrl_o` is 1.
  - `tx_word_o` is {MARK_CHAR, 8'h00}.
  - `start_pulse_o` is 1.
  In every other cycle the transmit data passes through.
- R3: A launch request is ignored when the link is not aligned or while a measurement is running. No start pulse is produced and the running count is not restarted.
- R4: A returned marker is a receive word with `rx_ctrl_i` = 1 and upper byte equal to MARK_CHAR. Bits [SLIDE_W-1:0] of that word are the far-end shift count. When one is seen while a measurement is running, `stop_pulse_o` and `result_valid_o` are high together for exactly one cycle, the cycle after the one in which the marker is seen.
- R5: `rt_delay_o` = D*WORD_BITS + `master_slide_i` + far-end shift count. D is the number of cycles from the start-pulse cycle to the cycle holding the returned marker (0 when they coincide). `master_slide_i` is sampled in the marker cycle. WORD_BITS defaults to 20.
- R6: `offset_o` equals `rt_delay_o` shifted right by one bit, valid in the same cycle.
- R7: Receive words are ignored while the block is idle. So are words whose upper byte matches but that have `rx_ctrl_i` = 0. Neither produces a stop pulse or a result.
- R8: If no marker arrives while the word counter goes from 0 to its all-ones value (2^CNT_W-1, CNT_W defaulting to 24), the block goes idle and sets `timeout_o` in the next cycle. The flag stays set until the next accepted launch.
- R9: `busy_o` is high from the start-pulse cycle through the cycle holding the returned marker, or through the last counted cycle on timeout. It is low otherwise.
- R10: Repeated measurements over an unchanged loop give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_aligned_i | input | 1 | Both directions are word-aligned |
| launch_i | input | 1 | Measurement request |
| master_slide_i | input | SLIDE_W | Local receiver word-alignment shift count |
| tx_data_i | input | 16 | Outgoing word from the user path |
| tx_ctrl_i | input | 1 | Upper byte of tx_data_i is a control character |
| tx_word_o | output | 16 | Word to the serializer |
| tx_ctrl_o | output | 1 | Upper byte of tx_word_o is a control character |
| rx_word_i | input | 16 | Word from the deserializer |
| rx_ctrl_i | input | 1 | Upper byte of rx_word_i is a control character |
| start_pulse_o | output | 1 | High in the marker transmit word |
| stop_pulse_o | output | 1 | High when the returned marker has been decoded |
| busy_o | output | 1 | Measurement in progress |
| timeout_o | output | 1 | Last measurement saw no returned marker |
| result_valid_o | output | 1 | One-cycle strobe for the result outputs |
| rt_delay_o | output | CNT_W+5 | Loop delay in unit intervals |
| offset_o | output | CNT_W+4 | Half the loop delay |

## Verification
Suppose the counter or state register starts at the wrong moment or misses a step. Then the result is off by a whole multiple of WORD_BITS, and this shows at the `result_valid_o` strobe of the very measurement concerned. A bad shift-count path instead gives an error smaller than WORD_BITS in the same strobe.

A stuck state register shows up in one of two ways. Either `busy_o` fails to drop in the cycle after the marker, or a start pulse appears for a launch that should have been refused, in the cycle after the request. A wrong saturation limit moves the rise of `timeout_o` away from cycle 2^CNT_W after the start pulse.

// File: rtl/rtmk_pkg.sv
package rtmk_pkg;
   typedef enum logic {
      MS_IDLE = 1'b0,
      MS_WAIT = 1'b1
   } meas_state_t;

   localparam int unsigned WORD_DW = 16;
   localparam int unsigned BYTE_DW = 8;
endpackage

// File: rtl/rtmk_tx_insert.sv
module rtmk_tx_insert
   import rtmk_pkg::*;
#(
   parameter logic [7:0] MARK_CHAR = 8'h5C
) (
   input  logic               send_i,
   input  logic [WORD_DW-1:0] data_i,
   input  logic               ctrl_i,
   output logic [WORD_DW-1:0] word_o,
   output logic               ctrl_o
);
   localparam logic [WORD_DW-1:0] MARK_WORD = {MARK_CHAR, {BYTE_DW{1'b0}}};

   always_comb begin
      if (send_i) begin
         word_o = MARK_WORD;
         ctrl_o = 1'b1;
      end else begin
         word_o = data_i;
         ctrl_o = ctrl_i;
      end
   end
endmodule

// File: rtl/rtmk_rx_detect.sv
module rtmk_rx_detect
   import rtmk_pkg::*;
#(
   parameter logic [7:0] MARK_CHAR = 8'h5C,
   parameter int unsigned SLIDE_W  = 5
) (
   input  logic [WORD_DW-1:0] word_i,
   input  logic               ctrl_i,
   output logic               hit_o,
   output logic [SLIDE_W-1:0] slide_o
);
   assign hit_o   = ctrl_i && (word_i[WORD_DW-1 -: BYTE_DW] == MARK_CHAR);
   assign slide_o = word_i[SLIDE_W-1:0];
endmodule

// File: rtl/rtmk_word_counter.sv
module rtmk_word_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             full_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (run_i && (cnt_q != CNT_MAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rtmk_combine.sv
module rtmk_combine #(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned SLIDE_W   = 5,
   parameter int unsigned WORD_BITS = 20,
   parameter int unsigned RES_W     = 29
) (
   input  logic [CNT_W-1:0]   words_i,
   input  logic [SLIDE_W-1:0] near_slide_i,
   input  logic [SLIDE_W-1:0] far_slide_i,
   output logic [RES_W-1:0]   total_o,
   output logic [RES_W-2:0]   half_o
);
   localparam bit IS_POW2 = ((WORD_BITS & (WORD_BITS - 1)) == 0);
   localparam int unsigned SH = $clog2(WORD_BITS);

   logic [RES_W-1:0] scaled;

   generate
      if (IS_POW2) begin : g_shift
         assign scaled = RES_W'(words_i) << SH;
      end else begin : g_mult
         assign scaled = RES_W'(words_i) * RES_W'(WORD_BITS);
      end
   endgenerate

   assign total_o = scaled + RES_W'(near_slide_i) + RES_W'(far_slide_i);
   assign half_o  = total_o[RES_W-1:1];
endmodule

// File: rtl/rtmk_delay_meter.sv
module rtmk_delay_meter
   import rtmk_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned SLIDE_W   = 5,
   parameter int unsigned WORD_BITS = 20,
   parameter logic [7:0]  MARK_CHAR = 8'h5C,
   localparam int unsigned RES_W    = CNT_W + $clog2(WORD_BITS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_aligned_i,
   input  logic               launch_i,
   input  logic [SLIDE_W-1:0] master_slide_i,
   input  logic [15:0]        tx_data_i,
   input  logic               tx_ctrl_i,
   output logic [15:0]        tx_word_o,
   output logic               tx_ctrl_o,
   input  logic [15:0]        rx_word_i,
   input  logic               rx_ctrl_i,
   output logic               start_pulse_o,
   output logic               stop_pulse_o,
   output logic               busy_o,
   output logic               timeout_o,
   output logic               result_valid_o,
   output logic [RES_W-1:0]   rt_delay_o,
   output logic [RES_W-2:0]   offset_o
);
   generate
      if (SLIDE_W < 1 || SLIDE_W > BYTE_DW) begin : g_bad_slide
         $error("SLIDE_W must fit in the low byte of the marker");
      end
      if (WORD_BITS < 2) begin : g_bad_word
         $error("WORD_BITS must be at least 2");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
   endgenerate

   meas_state_t      state_q;
   logic             send_q, valid_q, tout_q;
   logic [RES_W-1:0] result_q;
   logic [RES_W-2:0] half_q;

   logic               accept, rx_hit, waiting, cnt_full;
   logic [SLIDE_W-1:0] far_slide;
   logic [CNT_W-1:0]   words;
   logic [RES_W-1:0]   total;
   logic [RES_W-2:0]   half;

   assign waiting = (state_q == MS_WAIT);
   assign accept  = launch_i && link_aligned_i && !waiting;

   rtmk_tx_insert #(.MARK_CHAR(MARK_CHAR)) u_tx (
      .send_i (send_q),
      .data_i (tx_data_i),
      .ctrl_i (tx_ctrl_i),
      .word_o (tx_word_o),
      .ctrl_o (tx_ctrl_o)
   );

   rtmk_rx_detect #(.MARK_CHAR(MARK_CHAR), .SLIDE_W(SLIDE_W)) u_rx (
      .word_i  (rx_word_i),
      .ctrl_i  (rx_ctrl_i),
      .hit_o   (rx_hit),
      .slide_o (far_slide)
   );

   rtmk_word_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .run_i   (waiting && !rx_hit),
      .cnt_o   (words),
      .full_o  (cnt_full)
   );

   rtmk_combine #(
      .CNT_W(CNT_W), .SLIDE_W(SLIDE_W), .WORD_BITS(WORD_BITS), .RES_W(RES_W)
   ) u_comb (
      .words_i      (words),
      .near_slide_i (master_slide_i),
      .far_slide_i  (far_slide),
      .total_o      (total),
      .half_o       (half)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= MS_IDLE;
         send_q   <= 1'b0;
         valid_q  <= 1'b0;
         tout_q   <= 1'b0;
         result_q <= '0;
         half_q   <= '0;
      end else begin
         send_q  <= accept;
         valid_q <= 1'b0;
         if (accept) begin
            state_q <= MS_WAIT;
            tout_q  <= 1'b0;
         end else if (waiting) begin
            if (rx_hit) begin
               state_q  <= MS_IDLE;
               valid_q  <= 1'b1;
               result_q <= total;
               half_q   <= half;
            end else if (cnt_full) begin
               state_q <= MS_IDLE;
               tout_q  <= 1'b1;
            end
         end
      end
   end

   assign start_pulse_o  = send_q;
   assign stop_pulse_o   = valid_q;
   assign result_valid_o = valid_q;
   assign busy_o         = waiting;
   assign timeout_o      = tout_q;
   assign rt_delay_o     = result_q;
   assign offset_o       = half_q;
endmodule

// File: rtl/rtmk_delay_meter_chk.sv
module rtmk_delay_meter_chk #(
   parameter logic [7:0] MARK_CHAR = 8'h5C,
   parameter int unsigned RES_W    = 29
) (
   input logic             clk,
   input logic             rst_n,
   input logic             link_aligned_i,
   input logic             start_pulse_o,
   input logic             stop_pulse_o,
   input logic             busy_o,
   input logic             timeout_o,
   input logic             result_valid_o,
   input logic [15:0]      tx_word_o,
   input logic             tx_ctrl_o,
   input logic [RES_W-1:0] rt_delay_o,
   input logic [RES_W-2:0] offset_o
);
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o |=> !start_pulse_o);                                    // R2
   AST_START_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o |-> (tx_ctrl_o && tx_word_o[15:8] == MARK_CHAR));        // R2
   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o |-> !$past(busy_o));                                     // R3
   AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o |-> $past(link_aligned_i));                              // R3
   AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse_o |=> !stop_pulse_o);                                       // R4
   AST_STOP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse_o |-> ($past(busy_o) && !busy_o));                          // R9
   AST_OFFSET_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid_o |-> (offset_o == rt_delay_o[RES_W-1:1]));               // R6
   AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> (!busy_o && !result_valid_o));                    // R8
endmodule

bind rtmk_delay_meter rtmk_delay_meter_chk #(.MARK_CHAR(MARK_CHAR), .RES_W(RES_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .link_aligned_i (link_aligned_i),
   .start_pulse_o  (start_pulse_o),
   .stop_pulse_o   (stop_pulse_o),
   .busy_o         (busy_o),
   .timeout_o      (timeout_o),
   .result_valid_o (result_valid_o),
   .tx_word_o      (tx_word_o),
   .tx_ctrl_o      (tx_ctrl_o),
   .rt_delay_o     (rt_delay_o),
   .offset_o       (offset_o)
);

// File: tb/sim_rtmk_delay_meter.sv
module sim_rtmk_delay_meter;
   localparam int CNT_W = 10;
   localparam int SW    = 5;
   localparam int WB    = 20;
   localparam logic [7:0] MK = 8'h5C;
   localparam int RW    = CNT_W + 5;
   localparam int NV    = 6;
   localparam int VD  [NV] = '{0, 1, 7, 33, 100, 500};
   localparam int VMS [NV] = '{0, 19, 3, 31, 12, 5};
   localparam int VSS [NV] = '{0, 0, 17, 31, 8, 1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic aligned = 1'b0, launch = 1'b0, txc = 1'b0, rxc = 1'b0;
   logic [SW-1:0] ms = '0;
   logic [15:0] txd = 16'h0000, rxw = 16'h0000;
   logic [15:0] txw;
   logic txco, sp, stp, busy, tout, val;
   logic [RW-1:0] rt;
   logic [RW-2:0] ofs;
   int n_run = 0, n_fail = 0;
   int got_a, got_b;

   always #2.5 clk = ~clk;

   rtmk_delay_meter #(.CNT_W(CNT_W), .SLIDE_W(SW), .WORD_BITS(WB), .MARK_CHAR(MK)) u0 (
      .clk(clk), .rst_n(rst_n), .link_aligned_i(aligned), .launch_i(launch),
      .master_slide_i(ms), .tx_data_i(txd), .tx_ctrl_i(txc),
      .tx_word_o(txw), .tx_ctrl_o(txco), .rx_word_i(rxw), .rx_ctrl_i(rxc),
      .start_pulse_o(sp), .stop_pulse_o(stp), .busy_o(busy), .timeout_o(tout),
      .result_valid_o(val), .rt_delay_o(rt), .offset_o(ofs));

   task automatic chk(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // launch and check the start cycle; returns positioned in start-pulse cycle
   task automatic do_launch();
      @(negedge clk); launch = 1'b1;
      @(negedge clk); launch = 1'b0;
      chk("R2 start", sp, 1);
      chk("R2 marker word", txw, {MK, 8'h00});
      chk("R2 marker ctrl", txco, 1);
      chk("R9 busy", busy, 1);
   endtask

   task automatic measure(input int d, input int m, input int s, output int res);
      do_launch();
      repeat (d) @(negedge clk);
      rxw = {MK, 3'b000, s[4:0]}; rxc = 1'b1; ms = m[SW-1:0];
      chk("R9 busy at marker", busy, 1);
      @(negedge clk); rxw = 16'h0; rxc = 1'b0;
      chk("R4 stop", stp, 1);
      chk("R4 valid", val, 1);
      chk("R9 idle after", busy, 0);
      chk("R5 delay", rt, d * WB + m + s);
      chk("R6 offset", ofs, (d * WB + m + s) / 2);
      res = int'(rt);
      @(negedge clk);
      chk("R4 one cycle", val, 0);
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; txd = 16'hA5C3; txc = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 start", sp, 0);
      chk("R1 valid", val, 0);
      chk("R1 timeout", tout, 0);
      chk("R1 pass word", txw, 16'hA5C3);
      chk("R1 pass ctrl", txco, 1);
      txc = 1'b0;
      aligned = 1'b1;

      for (int i = 0; i < NV; i++) measure(VD[i], VMS[i], VSS[i], got_a);

      // R10: same loop twice
      measure(42, 9, 14, got_a);
      measure(42, 9, 14, got_b);
      chk("R10 constant", got_a, got_b);

      // R2 passthrough after pulse
      @(negedge clk);
      chk("R2 pass after", txw, 16'hA5C3);

      // R3 not aligned
      aligned = 1'b0; launch = 1'b1;
      @(negedge clk); launch = 1'b0;
      chk("R3 no start unaligned", sp, 0);
      chk("R3 idle unaligned", busy, 0);
      aligned = 1'b1;

      // R7 marker while idle
      rxw = {MK, 8'h03}; rxc = 1'b1;
      @(negedge clk); rxw = 16'h0; rxc = 1'b0;
      @(negedge clk);
      chk("R7 idle marker", stp, 0);

      // R3 launch while busy, R7 marker byte without ctrl
      do_launch();
      repeat (4) @(negedge clk);
      launch = 1'b1;
      @(negedge clk); launch = 1'b0;
      chk("R3 no restart pulse", sp, 0);
      rxw = {MK, 8'h02}; rxc = 1'b0;        // cycle k+5, not a marker
      @(negedge clk); rxw = 16'h0;
      chk("R7 no stop on data", stp, 0);
      chk("R7 still busy", busy, 1);
      repeat (4) @(negedge clk);              // cycle k+10
      rxw = {MK, 8'h02}; rxc = 1'b1; ms = 5'd1;
      @(negedge clk); rxw = 16'h0; rxc = 1'b0;
      chk("R3 count not restarted", rt, 10 * WB + 3);

      // R8 timeout
      do_launch();
      repeat (1023) @(negedge clk);
      chk("R8 busy before limit", busy, 1);
      chk("R8 no timeout yet", tout, 0);
      @(negedge clk);
      chk("R8 timeout set", tout, 1);
      chk("R8 idle", busy, 0);
      rxw = {MK, 8'h01}; rxc = 1'b1;
      @(negedge clk); rxw = 16'h0; rxc = 1'b0;
      @(negedge clk);
      chk("R8 late marker ignored", stp, 0);
      chk("R8 flag held", tout, 1);
      do_launch();
      chk("R8 flag cleared", tout, 0);
      repeat (2) @(negedge clk);
      rxw = {MK, 8'h00}; rxc = 1'b1; ms = 5'd0;
      @(negedge clk); rxw = 16'h0; rxc = 1'b0;
      chk("R5 after timeout", rt, 2 * WB);

      // R1 reset mid-measurement
      do_launch();
      rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1 reset busy", busy, 0);
      chk("R1 reset start", sp, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule